// File: doc/BRIEF.md
# Wrap-Around Bit Mask Generator

A combinational unit that builds 32-bit contiguous masks from a begin index and an end index. Bit numbering is big-endian: index 0 names the most significant bit and index 31 the least significant. A run of ones from begin to end is produced. When begin lies past end, the run wraps from the bottom of the word back to the top.

The unit has two independent paths that are evaluated at the same time. The fixed path serves rotate-and-insert logic and takes 5-bit begin and end fields directly. The generate path serves a mask-generate operation. It takes two full source register values, uses only their low five bits as indices, and applies the generate rules, which include an explicit all-ones result when begin equals end+1. When a record request is set, the generate result is also summarized as negative, positive or zero.

Top module: `wrap_mask_unit`

## Requirements
- R1: Bit numbering is big-endian. Begin = end = 0 on the fixed path gives 0x80000000, and begin = end = 31 gives 0x00000001.
- R2: On the fixed path with begin <= end, exactly the bits with big-endian indices begin through end are set.
- R3: On the fixed path with begin > end, the bits with index >= begin or index <= end are set, so the run wraps through bit 31 back to bit 0.
- R4: The generate path uses only bits [4:0] of each source value. Bits [31:5] of both sources have no effect on gen_mask_o or sign_o.
- R5: On the generate path with begin < end+1, gen_mask_o is the run from begin to end.
- R6: On the generate path with begin == end+1, gen_mask_o is 0xFFFFFFFF.
- R7: On the generate path with begin > end+1, gen_mask_o is the complement of the run from end+1 to begin-1.
- R8: With record_i = 1, sign_o is {negative, positive, zero} of gen_mask_o taken as a signed value: 3'b100 when bit 31 is set, 3'b001 when the value is zero, and 3'b010 otherwise. With record_i = 0, sign_o is 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fix_begin_i | input | 5 | Fixed-path begin index (big-endian) |
| fix_end_i | input | 5 | Fixed-path end index (big-endian) |
| fix_mask_o | output | 32 | Fixed-path mask |
| gen_begin_src_i | input | 32 | Generate-path begin source; low 5 bits used |
| gen_end_src_i | input | 32 | Generate-path end source; low 5 bits used |
| record_i | input | 1 | Request a sign summary of the generate result |
| gen_mask_o | output | 32 | Generate-path mask |
| sign_o | output | 3 | {negative, positive, zero} summary, or zero when no record is requested |

## Verification
The fixed mask and the generate mask, together with its sign summary, are all produced in the same evaluation from separate inputs. The bench drives both paths at once in every step. The fixed path gets the swapped pair (end, begin), while the generate path gets (begin, end) with varying garbage in the upper source bits and a toggling record request. Each of the three outputs is compared in that same step against its own bit-by-bit reference over all 1024 index pairs. Any leakage between the paths, or from the upper source bits, shows up as a mismatch.

// File: rtl/wmask_pkg.sv
package wmask_pkg;
  parameter int unsigned MASK_W = 32;
  localparam int unsigned IDX_W = $clog2(MASK_W);

  typedef struct packed {
    logic neg;
    logic pos;
    logic zero;
  } sign_t;
endpackage

// File: rtl/mask_span.sv
module mask_span #(
  parameter int unsigned W  = 32,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [IW-1:0] begin_i,
  input  logic [IW-1:0] end_i,
  output logic [W-1:0]  mask_o
);
  localparam logic [W-1:0]  ONES = '1;
  localparam logic [IW-1:0] TOP  = IW'(W - 1);

  logic [W-1:0] head, tail;

  always_comb begin
    head   = ONES >> begin_i;
    tail   = ONES << (TOP - end_i);
    mask_o = (begin_i <= end_i) ? (head & tail) : (head | tail);
  end

  always_comb begin
    if (begin_i <= end_i) begin
      a_r2_run_width: assert ($countones(mask_o) == int'(end_i) - int'(begin_i) + 1);
    end else begin
      a_r3_wrap_width: assert ($countones(mask_o) == int'(W) - (int'(begin_i) - int'(end_i)) + 1);
    end
  end
endmodule

// File: rtl/mask_gen_sel.sv
module mask_gen_sel #(
  parameter int unsigned W  = 32,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [IW-1:0] begin_i,
  input  logic [IW-1:0] end_i,
  output logic [W-1:0]  mask_o
);
  logic [IW:0]   end_p1;
  logic [IW-1:0] gap_lo, gap_hi;
  logic [W-1:0]  run_mask, gap_mask;

  assign end_p1 = {1'b0, end_i} + 1'b1;
  assign gap_lo = end_i + 1'b1;   // only used when begin > end+1
  assign gap_hi = begin_i - 1'b1;

  mask_span #(.W(W), .IW(IW)) u_run (
    .begin_i(begin_i), .end_i(end_i), .mask_o(run_mask)
  );

  mask_span #(.W(W), .IW(IW)) u_gap (
    .begin_i(gap_lo), .end_i(gap_hi), .mask_o(gap_mask)
  );

  always_comb begin
    if ({1'b0, begin_i} < end_p1)       mask_o = run_mask;
    else if ({1'b0, begin_i} == end_p1) mask_o = '1;
    else                                mask_o = ~gap_mask;
  end

  // both end points always lie inside the result
  always_comb begin
    a_r5_ends_set: assert (mask_o[W-1-int'(begin_i)] && mask_o[W-1-int'(end_i)]);
    if ({1'b0, begin_i} > end_p1) begin
      a_r7_gap_clear: assert ($countones(mask_o) == int'(W) - (int'(begin_i) - int'(end_i) - 1));
    end
  end
endmodule

// File: rtl/sign_summary.sv
module sign_summary
  import wmask_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         record_i,
  input  logic [W-1:0] value_i,
  output sign_t        sign_o
);
  always_comb begin
    sign_o = '0;
    if (record_i) begin
      sign_o.neg  = value_i[W-1];
      sign_o.zero = (value_i == '0);
      sign_o.pos  = !value_i[W-1] && (value_i != '0);
    end
  end

  always_comb begin
    a_r8_one_flag: assert ($onehot0(sign_o) && (record_i == ($countones(sign_o) == 1)));
  end
endmodule

// File: rtl/wrap_mask_unit.sv
module wrap_mask_unit
  import wmask_pkg::*;
#(
  parameter int unsigned W  = MASK_W,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [IW-1:0] fix_begin_i,
  input  logic [IW-1:0] fix_end_i,
  output logic [W-1:0]  fix_mask_o,
  input  logic [W-1:0]  gen_begin_src_i,
  input  logic [W-1:0]  gen_end_src_i,
  input  logic          record_i,
  output logic [W-1:0]  gen_mask_o,
  output logic [2:0]    sign_o
);
  sign_t sign_q;

  mask_span #(.W(W), .IW(IW)) u_fix (
    .begin_i(fix_begin_i), .end_i(fix_end_i), .mask_o(fix_mask_o)
  );

  mask_gen_sel #(.W(W), .IW(IW)) u_gen (
    .begin_i(gen_begin_src_i[IW-1:0]),
    .end_i  (gen_end_src_i[IW-1:0]),
    .mask_o (gen_mask_o)
  );

  sign_summary #(.W(W)) u_sign (
    .record_i(record_i), .value_i(gen_mask_o), .sign_o(sign_q)
  );

  assign sign_o = sign_q;

  always_comb begin
    if (fix_begin_i == fix_end_i) begin
      a_r1_single_bit: assert ($onehot(fix_mask_o) && fix_mask_o[W-1-int'(fix_begin_i)]);
    end
  end
endmodule

// File: tb/test_wrap_mask_unit.sv
module test_wrap_mask_unit;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [4:0]  fix_b, fix_e;
  logic [31:0] fix_m, gsrc_b, gsrc_e, gen_m;
  logic        rec;
  logic [2:0]  sgn;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  wrap_mask_unit i_wrap_mask_unit (
    .fix_begin_i(fix_b), .fix_end_i(fix_e), .fix_mask_o(fix_m),
    .gen_begin_src_i(gsrc_b), .gen_end_src_i(gsrc_e), .record_i(rec),
    .gen_mask_o(gen_m), .sign_o(sgn)
  );

  function automatic logic [31:0] ref_span(int b, int e);
    logic [31:0] m = '0;
    for (int i = 0; i < W; i++) begin
      if (b <= e) begin
        if (i >= b && i <= e) m[W-1-i] = 1'b1;
      end else begin
        if (i >= b || i <= e) m[W-1-i] = 1'b1;
      end
    end
    return m;
  endfunction

  function automatic logic [31:0] ref_gen(int b, int e);
    if (b < e + 1) return ref_span(b, e);
    if (b == e + 1) return 32'hFFFF_FFFF;
    return ~ref_span(e + 1, b - 1);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    fix_b = '0; fix_e = '0; gsrc_b = '0; gsrc_e = '0; rec = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // reset state: no record requested, sign summary idle
    check("R8 idle", {29'd0, sgn}, 32'd0);
    check("R1 msb", fix_m, 32'h8000_0000);

    @(negedge clk);
    fix_b = 5'd31; fix_e = 5'd31;
    #1 check("R1 lsb", fix_m, 32'h0000_0001);

    // R6 explicit case with garbage upper bits (R4)
    @(negedge clk);
    gsrc_b = 32'hDEAD_BEE0 | 32'd9; gsrc_e = 32'hFFFF_FFE0 | 32'd8; rec = 1'b1;
    #1 check("R6 begin eq end+1", gen_m, 32'hFFFF_FFFF);
    check("R8 neg", {29'd0, sgn}, 32'd4);

    for (int b = 0; b < W; b++) begin
      for (int e = 0; e < W; e++) begin
        logic [31:0] junk, exp_g;
        logic [2:0]  exp_s;
        @(negedge clk);
        junk   = 32'(b * 37 + e * 11 + 1) * 32'h0123_4567;
        fix_b  = 5'(e); fix_e = 5'(b);
        gsrc_b = (junk << 5) | 32'(b);
        gsrc_e = (~junk << 5) | 32'(e);
        rec    = 1'((b + e) & 1);
        #1;
        check(e <= b ? "R2 fixed run" : "R3 fixed wrap", fix_m, ref_span(e, b));
        exp_g = ref_gen(b, e);
        if (b < e + 1)       check("R5 R4 gen run", gen_m, exp_g);
        else if (b == e + 1) check("R6 R4 gen ones", gen_m, exp_g);
        else                 check("R7 R4 gen gap", gen_m, exp_g);
        if (!rec)                exp_s = 3'b000;
        else if (exp_g[31])      exp_s = 3'b100;
        else if (exp_g == '0)    exp_s = 3'b001;
        else                     exp_s = 3'b010;
        check("R8 sign", {29'd0, sgn}, {29'd0, exp_s});
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule